// File: doc/BRIEF.md
# Dynamic-Priority Shared Bus Arbiter

This block decides which of several processors owns a shared system bus. Each processor has a priority register inside the arbiter. A hardware scheduler rewrites these registers at run time through a dedicated priority bus, so each register tracks how important the task on that processor currently is. When the bus is free, it goes to the requesting processor with the highest stored priority. A processor that runs an unimportant task therefore cannot keep a processor that runs an urgent task off the bus.

A grant is one-hot. It stays with its owner for as long as the owner keeps requesting, and the requesters that lose stay blocked during that time. When stored priorities are equal, a round-robin pointer settles the order, starting with the processor after the last one granted. A priority load that arrives while the bus is owned leaves the current owner in place. The new values apply at the next arbitration.

Top module: `dyn_prio_arbiter`

## Requirements
- R1: While reset is asserted and directly after it, all grant outputs are low.
- R2: At most one grant bit is high in any cycle.
- R3: A grant bit can only rise for a processor whose request was high in the previous cycle. On an idle bus, the grant appears in the cycle after the request is seen.
- R4: Among processors requesting at the same time, the grant goes to the one with the numerically largest stored priority. A larger value means a more important processor.
- R5: When the load strobe is high at a clock edge, every priority register takes its field from the priority bus. Processor i uses bits [i*PRIO_W +: PRIO_W]. Reset clears every register to 0.
- R6: While the owner keeps its request high, the grant stays with the owner and all other requesters stay blocked, including requesters with a higher priority.
- R7: A priority load made while the bus is owned does not preempt the owner. The new values decide the next arbitration.
- R8: Ties in stored priority are broken round-robin, starting with the index after the last granted processor. After reset, the search starts at processor 0.
- R9: When the owner drops its request, the grant moves in the following cycle to the winner among the remaining requesters.
- R10: If no processor requests, all grants are low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | N_PROC | Bus request, one bit per processor |
| prio_load | input | 1 | Strobe that loads all priority registers |
| prio_bus | input | N_PROC*PRIO_W | Priority values from the scheduler, one field per processor |
| gnt | output | N_PROC | One-hot bus grant |

## Verification
A stale or corrupted priority register does not show up until the next arbitration. At that point the grant lands on a processor other than the one expected, one cycle after the bus frees up. A wrong round-robin pointer shows only when priorities tie, again as a wrong grant on the first re-arbitration after the pointer went wrong. A faulty hold condition shows up at once: the grant leaves a processor that is still requesting. The bench therefore sets up ties, in-flight priority loads and owner releases, and checks the grant one cycle after each change.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/dpa_prio_regs.sv
module dpa_prio_regs #(
  parameter int N_PROC = 3,
  parameter int PRIO_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic [N_PROC*PRIO_W-1:0] bus,
  output logic [N_PROC*PRIO_W-1:0] prio_q
);
  for (genvar i = 0; i < N_PROC; i++) begin : g_reg
    logic [PRIO_W-1:0] val_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_q <= '0;
      end else if (load) begin
        val_q <= bus[i*PRIO_W +: PRIO_W];
      end
    end

    assign prio_q[i*PRIO_W +: PRIO_W] = val_q;

    assert_load_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (val_q == $past(bus[i*PRIO_W +: PRIO_W])));
  end
endmodule

// File: rtl/dpa_pick.sv
module dpa_pick #(
  parameter int N_PROC = 3,
  parameter int PRIO_W = 4,
  parameter int IW     = 2
) (
  input  logic [N_PROC-1:0]        req,
  input  logic [N_PROC*PRIO_W-1:0] prio,
  input  logic [IW-1:0]            last_idx,
  output logic                     any,
  output logic [IW-1:0]            win_idx
);
  logic [PRIO_W-1:0] best_p;
  int                pos;

  // Visit processors in rotated order, starting after the last one granted.
  // Only a strictly larger priority replaces the current pick, so the first
  // processor in rotation wins a tie.
  always_comb begin
    any     = 1'b0;
    win_idx = '0;
    best_p  = '0;
    pos     = 0;
    for (int k = 0; k < N_PROC; k++) begin
      pos = int'(last_idx) + 1 + k;
      if (pos >= N_PROC) pos = pos - N_PROC;
      if (pos >= N_PROC) pos = pos - N_PROC;
      if (req[pos] && (!any || (prio[pos*PRIO_W +: PRIO_W] > best_p))) begin
        any     = 1'b1;
        win_idx = IW'(pos);
        best_p  = prio[pos*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/dpa_grant_ctrl.sv
module dpa_grant_ctrl #(
  parameter int N_PROC = 3,
  parameter int IW     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PROC-1:0] req,
  input  logic              any,
  input  logic [IW-1:0]     win_idx,
  output logic [N_PROC-1:0] gnt,
  output logic [IW-1:0]     last_idx
);
  logic [N_PROC-1:0] gnt_q, gnt_d;
  logic [IW-1:0]     last_q, last_d;
  logic              owner_keep;
  logic              last_en;

  assign owner_keep = |(gnt_q & req);
  assign last_en    = !owner_keep && any;

  always_comb begin
    gnt_d  = gnt_q;
    last_d = last_q;
    if (!owner_keep) begin
      gnt_d = '0;
      if (any) begin
        gnt_d[win_idx] = 1'b1;
        last_d         = win_idx;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_q  <= '0;
      last_q <= IW'(N_PROC - 1);
    end else begin
      gnt_q <= gnt_d;
      if (last_en) begin
        last_q <= last_d;
      end
    end
  end

  assign gnt      = gnt_q;
  assign last_idx = last_q;

  assert_gnt_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_q));

  assert_idle_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0) |=> (gnt_q == '0));

  for (genvar i = 0; i < N_PROC; i++) begin : g_chk
    assert_hold_owner_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_q[i] && req[i]) |=> gnt_q[i]);

    assert_grant_requested_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gnt_q[i]) |-> $past(req[i]));
  end
endmodule

// File: rtl/dyn_prio_arbiter.sv
module dyn_prio_arbiter
  import dpa_pkg::*;
#(
  parameter int N_PROC = 3,
  parameter int PRIO_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_PROC-1:0]        req,
  input  logic                     prio_load,
  input  logic [N_PROC*PRIO_W-1:0] prio_bus,
  output logic [N_PROC-1:0]        gnt
);
  localparam int IW = idx_bits(N_PROC);

  logic [N_PROC*PRIO_W-1:0] prio_q;
  logic [IW-1:0]            last_idx;
  logic [IW-1:0]            win_idx;
  logic                     any;

  dpa_prio_regs #(.N_PROC(N_PROC), .PRIO_W(PRIO_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (prio_load),
    .bus    (prio_bus),
    .prio_q (prio_q)
  );

  dpa_pick #(.N_PROC(N_PROC), .PRIO_W(PRIO_W), .IW(IW)) u_pick (
    .req      (req),
    .prio     (prio_q),
    .last_idx (last_idx),
    .any      (any),
    .win_idx  (win_idx)
  );

  dpa_grant_ctrl #(.N_PROC(N_PROC), .IW(IW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .any      (any),
    .win_idx  (win_idx),
    .gnt      (gnt),
    .last_idx (last_idx)
  );

  // A newly granted processor must not rank below any processor that was
  // requesting alongside it.
  for (genvar i = 0; i < N_PROC; i++) begin : g_win
    for (genvar j = 0; j < N_PROC; j++) begin : g_cmp
      if (i != j) begin : g_pair
        assert_highest_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
          ($rose(gnt[i]) && $past(req[j])) |->
            ($past(prio_q[i*PRIO_W +: PRIO_W]) >= $past(prio_q[j*PRIO_W +: PRIO_W])));
      end
    end
  end
endmodule

// File: tb/dyn_prio_arbiter_tb_top.sv
module dyn_prio_arbiter_tb_top;
  localparam int N  = 3;
  localparam int PW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  req;
  logic          prio_load;
  logic [N*PW-1:0] prio_bus;
  logic [N-1:0]  gnt;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  dyn_prio_arbiter #(.N_PROC(N), .PRIO_W(PW)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .prio_load (prio_load),
    .prio_bus  (prio_bus),
    .gnt       (gnt)
  );

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic check(input string tag, input logic [N-1:0] exp);
    checks++;
    if (gnt !== exp) begin
      errors++;
      $display("FAIL %s: gnt=%b expected=%b", tag, gnt, exp);
    end
    checks++;
    if (!$onehot0(gnt)) begin
      errors++;
      $display("FAIL R2: gnt=%b expected at most one bit", gnt);
    end
  endtask

  task automatic load_prio(input logic [PW-1:0] p2, input logic [PW-1:0] p1,
                           input logic [PW-1:0] p0);
    prio_bus  = {p2, p1, p0};
    prio_load = 1'b1;
    tick();
    prio_load = 1'b0;
  endtask

  task automatic t_reset();
    check("R1", 3'b000);
    req = 3'b111;
    tick();
    check("R8 R5 reset tie starts at 0", 3'b001);
    req = 3'b000;
    tick();
    check("R10", 3'b000);
  endtask

  task automatic t_priority();
    load_prio(4'd5, 4'd7, 4'd2);
    req = 3'b111;
    tick();
    check("R4", 3'b010);
    tick();
    check("R6 owner held, others blocked", 3'b010);
    load_prio(4'd5, 4'd7, 4'd15);
    check("R7 no preempt on load", 3'b010);
    req = 3'b101;
    tick();
    check("R9 R7 new value decides", 3'b001);
  endtask

  task automatic t_tie();
    req = 3'b000;
    tick();
    check("R10", 3'b000);
    load_prio(4'd3, 4'd3, 4'd3);
    req = 3'b111;
    tick();
    check("R8 after last=0", 3'b010);
    req = 3'b101;
    tick();
    check("R8 after last=1", 3'b100);
    req = 3'b001;
    tick();
    check("R8 wrap", 3'b001);
    req = 3'b000;
    tick();
    check("R10", 3'b000);
  endtask

  task automatic t_lone();
    load_prio(4'd1, 4'd9, 4'd9);
    req = 3'b100;
    tick();
    check("R3 lone low requester", 3'b100);
    req = 3'b110;
    tick();
    check("R6 higher requester blocked", 3'b100);
    req = 3'b010;
    tick();
    check("R9 handover", 3'b010);
    req = 3'b000;
    tick();
    check("R10", 3'b000);
  endtask

  initial begin
    rst_n     = 1'b0;
    req       = '0;
    prio_load = 1'b0;
    prio_bus  = '0;
    repeat (3) tick();
    check("R1 in reset", 3'b000);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_priority();
    t_tie();
    t_lone();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule